// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timing Generator

This block times the read and write strobes of programmed-I/O transfers on a two-channel IDE host interface. A host request names the channel, the drive, the direction and whether the access targets the command block or the data port. The block picks the timing registers for that target and splits the transfer into three phases, all counted in host clocks: address setup with both strobes high, an active phase with one strobe low, and recovery with both strobes high again. The active phase stretches while the drive holds IORDY low. A one-cycle done pulse marks the last recovery clock.

Only one transfer runs at a time, across both channels. `busy` is high from the clock after acceptance until recovery ends. A request raised while `busy` is high is dropped, so the requester keeps it up, or raises it again, once `busy` falls. Timing registers are written through a simple byte write port. The states are `ST_IDLE`, `ST_SETUP`, `ST_ACTIVE` and `ST_RECOVER`. The transitions are:
- accept: `ST_IDLE` to `ST_SETUP` on a request.
- setup_done: `ST_SETUP` to `ST_ACTIVE` when the setup count runs out.
- strobe_release: `ST_ACTIVE` to `ST_RECOVER` when the minimum active count has elapsed and IORDY is sampled high.
- recovery_done: `ST_RECOVER` to `ST_IDLE` when the recovery count runs out.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: Bits 7:6 of the selected setup register give the setup length: 00 gives 4 clocks, 01 gives 2, 10 gives 3 and 11 gives 5.
- R2: Bits 7:4 of the selected data timing register give the minimum active length in clocks. The value 0 stands for 16.
- R3: Bits 3:0 of the selected data timing register give the recovery length, with 0 standing for 16. When `late_rev` is high at acceptance, one extra recovery clock is added.
- R4: On channel 0, drive 0 uses the setup register at address 0 and the data register at address 1. Drive 1 uses address 2 for setup and address 3 for data.
- R5: On channel 1, both drives share the setup register at address 4 and the data register at address 5.
- R6: A command-block request (`req_cmd`=1) takes its active and recovery lengths from the register at address 6. Its setup length still comes from the drive's setup register.
- R7: While IORDY is sampled low, the active phase is extended. The strobe is released only after IORDY is sampled high at or after the end of the minimum active count.
- R8: A request is accepted only while `busy` is low. A request presented while `busy` is high has no effect, and the transfer in progress completes unchanged.
- R9: `done` is high for exactly one clock, the last recovery clock. `busy` is low in the following clock.
- R10: After reset, `busy` and `done` are low, both strobes are high and every register reads as 0. A transfer therefore takes 4 setup, 16 active and 16 recovery clocks.
- R11: `ra_off_sec[0]` and `ra_off_sec[1]` follow bits 2 and 3 of the shared channel-1 setup register at address 4.
- R12: A read (`req_write`=0) drives only `dior_n` low in the active phase. A write drives only `diow_n` low. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register index (0 to 6; 7 is unused) |
| cfg_wdata | input | 8 | Register write data |
| late_rev | input | 1 | Recovery field stored one below the real count |
| req_valid | input | 1 | Transfer request |
| req_chan | input | 1 | Channel select |
| req_drive | input | 1 | Drive select within the channel |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cmd | input | 1 | 1 for command-block access, 0 for data port |
| iordy | input | 1 | Drive ready; low stretches the active phase |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last recovery clock |
| ra_off_sec | output | 2 | Read-ahead disable for channel-1 drives 0 and 1 |

## Verification
The properties assume that IORDY and the request inputs are synchronous to `clk` and settled at each rising edge. They also assume that a requester does not depend on a request being seen while `busy` is high. The bench drives every input on the falling edge. It raises IORDY low windows only around the active phase it measures, and it changes `late_rev` and the register contents only between transfers. The busy test deliberately presents a conflicting request mid-transfer to show that the request is dropped.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 7;
    localparam int ADDR_W   = 3;

    // register indices (selection logic depends on them)
    localparam int IX_P0_SETUP  = 0;
    localparam int IX_P0_DATA   = 1;
    localparam int IX_P1_SETUP  = 2;
    localparam int IX_P1_DATA   = 3;
    localparam int IX_SEC_SETUP = 4;
    localparam int IX_SEC_DATA  = 5;
    localparam int IX_CMD_DATA  = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER
    } pio_state_e;
endpackage

// File: rtl/ide_pio_regs.sv
module ide_pio_regs
    import ide_pio_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int NR = NUM_REGS,
    parameter int AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [RW-1:0]         wdata,
    output logic [NR-1:0][RW-1:0] regs
);
    for (genvar i = 0; i < NR; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && (addr == AW'(i))) begin
                regs[i] <= wdata;
            end
        end
    end
endmodule

// File: rtl/ide_pio_tsel.sv
module ide_pio_tsel
    import ide_pio_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
    input  logic                           chan,
    input  logic                           drive,
    input  logic                           cmd,
    input  logic                           late_rev,
    output logic [CW-1:0]                  setup_len,
    output logic [CW-1:0]                  act_len,
    output logic [CW-1:0]                  rec_len
);
    logic [REG_W-1:0] setup_reg;
    logic [REG_W-1:0] data_reg;
    logic [3:0]       act_nib;
    logic [3:0]       rec_nib;

    always_comb begin
        if (chan) begin
            setup_reg = regs[IX_SEC_SETUP];
            data_reg  = regs[IX_SEC_DATA];
        end else if (drive) begin
            setup_reg = regs[IX_P1_SETUP];
            data_reg  = regs[IX_P1_DATA];
        end else begin
            setup_reg = regs[IX_P0_SETUP];
            data_reg  = regs[IX_P0_DATA];
        end
        if (cmd) begin
            data_reg = regs[IX_CMD_DATA];
        end
    end

    assign act_nib = data_reg[7:4];
    assign rec_nib = data_reg[3:0];

    always_comb begin
        unique case (setup_reg[7:6])
            2'b00: setup_len = CW'(4);
            2'b01: setup_len = CW'(2);
            2'b10: setup_len = CW'(3);
            2'b11: setup_len = CW'(5);
        endcase
        act_len = (act_nib == 4'd0) ? CW'(16) : CW'(act_nib);
        rec_len = ((rec_nib == 4'd0) ? CW'(16) : CW'(rec_nib)) + CW'(late_rev);
    end
endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
    import ide_pio_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              late_rev,
    input  logic              req_valid,
    input  logic              req_chan,
    input  logic              req_drive,
    input  logic              req_write,
    input  logic              req_cmd,
    input  logic              iordy,
    output logic              dior_n,
    output logic              diow_n,
    output logic              busy,
    output logic              done,
    output logic [1:0]        ra_off_sec
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    logic [CNT_W-1:0] setup_len, act_len, rec_len;
    logic [CNT_W-1:0] act_q, rec_q, cnt_q;
    logic             wr_q;
    pio_state_e       state_q;

    ide_pio_regs #(.RW(REG_W), .NR(NUM_REGS), .AW(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .regs  (regs)
    );

    ide_pio_tsel #(.CW(CNT_W)) u_tsel (
        .regs      (regs),
        .chan      (req_chan),
        .drive     (req_drive),
        .cmd       (req_cmd),
        .late_rev  (late_rev),
        .setup_len (setup_len),
        .act_len   (act_len),
        .rec_len   (rec_len)
    );

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
            rec_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_SETUP;
                        cnt_q   <= setup_len;
                        act_q   <= act_len;
                        rec_q   <= rec_len;
                        wr_q    <= req_write;
                    end
                end
                ST_SETUP: begin
                    if (cnt_q == ONE) begin
                        state_q <= ST_ACTIVE;
                        cnt_q   <= act_q;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                ST_ACTIVE: begin
                    if (cnt_q == ONE) begin
                        if (iordy) begin
                            state_q <= ST_RECOVER;
                            cnt_q   <= rec_q;
                        end
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                ST_RECOVER: begin
                    if (cnt_q == ONE) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        dior_n = 1'b1;
        diow_n = 1'b1;
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_RECOVER) && (cnt_q == ONE);
        if (state_q == ST_ACTIVE) begin
            if (wr_q) diow_n = 1'b0;
            else      dior_n = 1'b0;
        end
    end

    assign ra_off_sec = regs[IX_SEC_SETUP][3:2];
endmodule

// File: rtl/ide_pio_strobe_gen_chk.sv
module ide_pio_strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic iordy,
    input logic dior_n,
    input logic diow_n,
    input logic busy,
    input logic done
);
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    p_strobe_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> busy);

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && dior_n && diow_n));

    p_hold_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n && !iordy) |=> !dior_n);

    p_hold_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!diow_n && !iordy) |=> !diow_n);
endmodule

bind ide_pio_strobe_gen ide_pio_strobe_gen_chk u_chk (.*);

// File: tb/ide_pio_strobe_gen_test.sv
module ide_pio_strobe_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       late_rev = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_chan = 1'b0;
    logic       req_drive = 1'b0;
    logic       req_write = 1'b0;
    logic       req_cmd = 1'b0;
    logic       iordy = 1'b1;
    logic       dior_n, diow_n, busy, done;
    logic [1:0] ra_off_sec;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [0:6];

    always #2.5 clk = ~clk;

    ide_pio_strobe_gen uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int setup_of(input logic [7:0] b);
        case (b[7:6])
            2'b00: return 4;
            2'b01: return 2;
            2'b10: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic int nib(input logic [3:0] n);
        return (n == 4'd0) ? 16 : int'(n);
    endfunction

    task automatic wr_reg(input int a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 7) model[a] = d;
    endtask

    // run one transfer; k: IORDY low until active clock k
    task automatic xfer(input bit ch, input bit dr, input bit w, input bit cm,
                        input int k, input string tag);
        int si, di, s_e, a_e, r_e, ns, na, nr, nd, done_at, wrong;
        si = ch ? 4 : (dr ? 2 : 0);
        di = cm ? 6 : (ch ? 5 : (dr ? 3 : 1));
        s_e = setup_of(model[si]);
        a_e = nib(model[di][7:4]);
        if (k > a_e) a_e = k;
        r_e = nib(model[di][3:0]) + (late_rev ? 1 : 0);
        ns = 0; na = 0; nr = 0; nd = 0; done_at = -1; wrong = 0;
        @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_drive = dr; req_write = w; req_cmd = cm;
        iordy = (k <= 1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int g = 0; g < 300; g++) begin
            if (!busy) break;
            if (w ? !dior_n : !diow_n) wrong++;
            if (w ? !diow_n : !dior_n) begin
                na++;
                iordy = (na >= k);
            end else if (na == 0) ns++;
            else nr++;
            if (done) begin nd++; done_at = nr; end
            @(negedge clk);
        end
        iordy = 1'b1;
        chk(ns == s_e, {"R1 setup ", tag}, ns, s_e);
        chk(na == a_e, {"R2/R7 active ", tag}, na, a_e);
        chk(nr == r_e, {"R3 recovery ", tag}, nr, r_e);
        chk(nd == 1 && done_at == r_e, {"R9 done ", tag}, done_at, r_e);
        chk(wrong == 0, {"R12 strobe ", tag}, wrong, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        void'($urandom(32'h1DE5));
        for (int i = 0; i < 7; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done, "R10 busy/done", busy + done, 0);
        chk(dior_n && diow_n, "R10 strobes", {dior_n, diow_n}, 3);
        chk(ra_off_sec == 2'b00, "R10 ra", ra_off_sec, 0);
        xfer(0, 0, 0, 0, 0, "R10 default");

        // R4 primary per-drive
        wr_reg(0, 8'h40); wr_reg(1, 8'h35);
        wr_reg(2, 8'h80); wr_reg(3, 8'h72);
        xfer(0, 0, 0, 0, 0, "R4 p0");
        xfer(0, 1, 1, 0, 0, "R4 p1");
        // R5 shared secondary
        wr_reg(4, 8'hCC); wr_reg(5, 8'h21);
        chk(ra_off_sec == 2'b11, "R11 ra both", ra_off_sec, 3);
        xfer(1, 0, 1, 0, 0, "R5 s0");
        xfer(1, 1, 0, 0, 0, "R5 s1");
        wr_reg(4, 8'h04);
        chk(ra_off_sec == 2'b01, "R11 ra drive0", ra_off_sec, 1);
        // R6 command register
        wr_reg(6, 8'h14);
        xfer(0, 1, 0, 1, 0, "R6 cmd p1");
        xfer(1, 0, 1, 1, 0, "R6 cmd s0");
        // R3 late revision, zero nibble
        late_rev = 1'b1;
        wr_reg(1, 8'h30);
        xfer(0, 0, 1, 0, 0, "R3 late zero");
        wr_reg(1, 8'h05);
        xfer(0, 0, 0, 0, 0, "R3 late act16");
        late_rev = 1'b0;
        // R7 IORDY stretch
        wr_reg(1, 8'h32);
        xfer(0, 0, 0, 0, 10, "R7 stretch");
        xfer(0, 0, 1, 0, 2, "R7 short");

        // R8 request during busy is dropped
        wr_reg(1, 8'h44);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 0; req_drive = 0; req_write = 0; req_cmd = 0;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int wlow, gone;
            wlow = 0;
            repeat (4) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_chan = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            for (int g = 0; g < 100; g++) begin
                if (!diow_n) wlow++;
                if (!busy) break;
                @(negedge clk);
            end
            gone = 0;
            repeat (3) begin
                @(negedge clk);
                if (busy || !diow_n) gone++;
            end
            chk(wlow == 0, "R8 no write strobe", wlow, 0);
            chk(gone == 0, "R8 stays idle", gone, 0);
        end

        // constrained random
        for (int n = 0; n < 40; n++) begin
            int a;
            a = $urandom_range(0, 6);
            wr_reg(a, 8'($urandom));
            late_rev = 1'($urandom);
            xfer(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 3) == 0) ? $urandom_range(0, 20) : 0, "rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule